// File: doc/BRIEF.md
# Pixel Component Extraction Unit

This unit sits between a framebuffer read stream and the display output path. Each incoming pixel word is one to four bytes wide. The unit turns it into an 8-bit red, green and blue triple. Software programs a format register that gives the number of bytes in each pixel. It also programs three selector registers, one per colour. A selector names the lowest bit of the field, the field length (0 to 15 bits) and a fallback value for its colour.

Each colour is handled on its own. The field is cut out of the pixel word and normalised to 8 bits. A field shorter than 8 bits is left-justified and its top bits fill the low end. A field longer than 8 bits keeps only its top 8 bits. The fallback value takes the place of the extracted value in three cases: the field length is zero, the pixel is marked as lying in blanking, or the stream reports an underrun. Results appear on registered outputs one clock after the input beat.

Top module: `pix_comp_extract`

## Requirements
- R1: After reset, `out_valid` is 0 and all three components are 0. Every configuration field resets to zero, so each pixel is treated as one byte wide with zero-length fields and fallback values of 0.
- R2: A write with `cfg_addr`=0 sets bytes-per-pixel minus one from `cfg_wdata[4:3]`. Addresses 1, 2 and 3 load the red, green and blue selectors: fallback from `[23:16]`, length from `[11:8]`, lowest bit index from `[4:0]`. The write takes effect on the next beat.
- R3: Pixel bytes at or above the programmed byte count are read as zero before extraction.
- R4: A component takes `length` bits of the masked word starting at the programmed lowest bit. Positions past bit 31 read as zero.
- R5: A field of 1 to 7 bits is placed in the top bits of the 8-bit component. The field pattern then repeats into the lower bits. For example, a 5-bit field of 0x1F gives 0xFF, and a 3-bit field of 0b101 gives 0xB6.
- R6: A field of exactly 8 bits is passed through as it is. A field of 9 to 15 bits is reduced to its top 8 bits.
- R7: A component whose length is zero outputs its own fallback value.
- R8: When `in_active` is 0 on a valid beat, all three components output their fallback values.
- R9: When `in_underrun` is 1 on a valid beat, all three components output their fallback values.
- R10: `out_valid` equals `in_valid` delayed by exactly one clock. The components update one clock after a valid beat.
- R11: While `in_valid` is 0, the components hold their last values, whatever the other stream inputs do.
- R12: Writing one colour's selector leaves the results of the other two colours unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 format, 1 red, 2 green, 3 blue |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Pixel beat present |
| in_active | input | 1 | Pixel lies inside the visible area |
| in_underrun | input | 1 | Stream could not supply real pixel data |
| in_pixel | input | 32 | Raw pixel word, byte 0 in bits [7:0] |
| out_valid | output | 1 | Registered copy of `in_valid` |
| out_red | output | 8 | Red component |
| out_green | output | 8 | Green component |
| out_blue | output | 8 | Blue component |

## Verification
The assertions assume that `cfg_addr` and `cfg_wdata` carry known values whenever `cfg_we` is high. They also assume that `in_active`, `in_underrun` and `in_pixel` are defined on every beat where `in_valid` is high. The fallback checks compare against the selector value from the cycle before the output edge. A configuration write in the same cycle as a beat is therefore allowed. To keep the bench's expected values simple, the stimulus still performs every write on cycles with no beat. Every input changes half a clock away from the sampling edge, so each stimulus value is settled before the design samples it.

// File: rtl/pce_pkg.sv
package pce_pkg;
   localparam int NUM_CHAN     = 3;
   localparam int FMT_LSB      = 3;
   localparam int SEL_OFFS_LSB = 0;
   localparam int SEL_LEN_LSB  = 8;
   localparam int SEL_DFLT_LSB = 16;

   typedef enum logic [1:0] {
      REG_FORMAT = 2'd0,
      REG_SEL_R  = 2'd1,
      REG_SEL_G  = 2'd2,
      REG_SEL_B  = 2'd3
   } reg_addr_e;
endpackage

// File: rtl/pce_cfg_regs.sv
module pce_cfg_regs
   import pce_pkg::*;
#(
   parameter int REG_W  = 32,
   parameter int COMP_W = 8,
   parameter int LEN_W  = 4,
   parameter int OFFS_W = 5,
   parameter int BPP_W  = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we,
   input  logic [1:0]                       addr,
   input  logic [REG_W-1:0]                 wdata,
   output logic [BPP_W-1:0]                 bpp_m1,
   output logic [NUM_CHAN-1:0][COMP_W-1:0]  dflt,
   output logic [NUM_CHAN-1:0][LEN_W-1:0]   len,
   output logic [NUM_CHAN-1:0][OFFS_W-1:0]  offs
);
   if (SEL_DFLT_LSB + COMP_W > REG_W) begin : g_bad_dflt
      $error("fallback field does not fit the register");
   end
   if (SEL_LEN_LSB + LEN_W > SEL_DFLT_LSB) begin : g_bad_len
      $error("length field overlaps fallback field");
   end
   if (SEL_OFFS_LSB + OFFS_W > SEL_LEN_LSB) begin : g_bad_offs
      $error("offset field overlaps length field");
   end
   if (FMT_LSB + BPP_W > REG_W) begin : g_bad_fmt
      $error("format field does not fit the register");
   end

   logic unused_wdata;
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n)
         bpp_m1 <= '0;
      else if (we && addr == REG_FORMAT)
         bpp_m1 <= wdata[FMT_LSB +: BPP_W];
   end

   // R2
   fmt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == REG_FORMAT) |=> bpp_m1 == $past(wdata[FMT_LSB +: BPP_W]));

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_sel
      localparam logic [1:0] MY_ADDR = 2'(int'(REG_SEL_R) + c);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            dflt[c] <= '0;
            len[c]  <= '0;
            offs[c] <= '0;
         end else if (we && addr == MY_ADDR) begin
            dflt[c] <= wdata[SEL_DFLT_LSB +: COMP_W];
            len[c]  <= wdata[SEL_LEN_LSB +: LEN_W];
            offs[c] <= wdata[SEL_OFFS_LSB +: OFFS_W];
         end
      end

      // R2
      sel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (we && addr == MY_ADDR) |=>
            (dflt[c] == $past(wdata[SEL_DFLT_LSB +: COMP_W]) &&
             len[c]  == $past(wdata[SEL_LEN_LSB +: LEN_W]) &&
             offs[c] == $past(wdata[SEL_OFFS_LSB +: OFFS_W])));

      // R12
      sel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (we && addr != MY_ADDR) |=> $stable(len[c]) && $stable(offs[c]) && $stable(dflt[c]));
   end
endmodule

// File: rtl/pce_chan_extract.sv
module pce_chan_extract #(
   parameter int PIX_W  = 32,
   parameter int COMP_W = 8,
   parameter int LEN_W  = 4,
   parameter int OFFS_W = 5
) (
   input  logic [PIX_W-1:0]  pix,
   input  logic [OFFS_W-1:0] offs,
   input  logic [LEN_W-1:0]  len,
   input  logic [COMP_W-1:0] dflt,
   input  logic              force_dflt,
   output logic [COMP_W-1:0] comp
);
   localparam int MAX_LEN = (1 << LEN_W) - 1;

   if (PIX_W < COMP_W) begin : g_bad_width
      $error("pixel word narrower than component");
   end

   logic [PIX_W-1:0]  shifted;
   logic [PIX_W-1:0]  fmask;
   logic [PIX_W-1:0]  field;
   logic [COMP_W-1:0] rep;
   logic [COMP_W-1:0] scaled;

   assign shifted = pix >> offs;
   assign fmask   = ~({PIX_W{1'b1}} << len);
   assign field   = shifted & fmask;

   // short fields: left-justify, then fill the low bits with copies
   always_comb begin
      logic [COMP_W-1:0] lj;
      lj  = '0;
      rep = '0;
      if (len != '0 && int'(len) < COMP_W) begin
         lj = field[COMP_W-1:0] << (COMP_W - int'(len));
         for (int k = 0; k < COMP_W; k++)
            rep = rep | (lj >> (k * int'(len)));
      end
   end

   if (MAX_LEN >= COMP_W) begin : g_wide
      logic [PIX_W-1:0] trunc;
      always_comb begin
         trunc = '0;
         if (int'(len) >= COMP_W)
            trunc = field >> (int'(len) - COMP_W);
      end
      assign scaled = (int'(len) >= COMP_W) ? trunc[COMP_W-1:0] : rep;
   end else begin : g_narrow
      assign scaled = rep;
   end

   assign comp = (force_dflt || len == '0) ? dflt : scaled;
endmodule

// File: rtl/pix_comp_extract.sv
module pix_comp_extract
   import pce_pkg::*;
#(
   parameter int PIX_BYTES = 4,
   parameter int COMP_W    = 8,
   parameter int LEN_W     = 4,
   parameter int OFFS_W    = 5,
   parameter int REG_W     = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [1:0]               cfg_addr,
   input  logic [REG_W-1:0]         cfg_wdata,
   input  logic                     in_valid,
   input  logic                     in_active,
   input  logic                     in_underrun,
   input  logic [8*PIX_BYTES-1:0]   in_pixel,
   output logic                     out_valid,
   output logic [COMP_W-1:0]        out_red,
   output logic [COMP_W-1:0]        out_green,
   output logic [COMP_W-1:0]        out_blue
);
   localparam int PIX_W = 8 * PIX_BYTES;
   localparam int BPP_W = (PIX_BYTES > 1) ? $clog2(PIX_BYTES) : 1;

   if (PIX_BYTES < 1 || PIX_BYTES > 4) begin : g_bad_bytes
      $error("PIX_BYTES must be 1 to 4");
   end
   if ((1 << OFFS_W) < PIX_W) begin : g_bad_offs
      $error("offset field cannot address every pixel bit");
   end

   logic [BPP_W-1:0]                bpp_m1;
   logic [NUM_CHAN-1:0][COMP_W-1:0] dflt;
   logic [NUM_CHAN-1:0][LEN_W-1:0]  len;
   logic [NUM_CHAN-1:0][OFFS_W-1:0] offs;
   logic [PIX_W-1:0]                pix_masked;
   logic [NUM_CHAN-1:0][COMP_W-1:0] comp_d;
   logic [NUM_CHAN-1:0][COMP_W-1:0] comp_q;
   logic                            use_dflt;

   pce_cfg_regs #(
      .REG_W(REG_W), .COMP_W(COMP_W), .LEN_W(LEN_W), .OFFS_W(OFFS_W), .BPP_W(BPP_W)
   ) i_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .bpp_m1(bpp_m1), .dflt(dflt), .len(len), .offs(offs)
   );

   for (genvar b = 0; b < PIX_BYTES; b++) begin : g_byte
      assign pix_masked[b*8 +: 8] = (int'(bpp_m1) >= b) ? in_pixel[b*8 +: 8] : 8'h00;
   end

   assign use_dflt = !in_active || in_underrun;

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
      pce_chan_extract #(
         .PIX_W(PIX_W), .COMP_W(COMP_W), .LEN_W(LEN_W), .OFFS_W(OFFS_W)
      ) i_chan (
         .pix(pix_masked), .offs(offs[c]), .len(len[c]), .dflt(dflt[c]),
         .force_dflt(use_dflt), .comp(comp_d[c])
      );

      // R7
      zero_len_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && len[c] == '0) |=> comp_q[c] == $past(dflt[c]));
      // R8
      blank_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !in_active) |=> comp_q[c] == $past(dflt[c]));
      // R9
      underrun_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_underrun) |=> comp_q[c] == $past(dflt[c]));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         comp_q    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid)
            comp_q <= comp_d;
      end
   end

   assign out_red   = comp_q[0];
   assign out_green = comp_q[1];
   assign out_blue  = comp_q[2];

   // R10
   valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R10
   idle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R11
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(comp_q));
endmodule

// File: tb/test_pix_comp_extract.sv
module test_pix_comp_extract;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        in_valid = 1'b0;
   logic        in_active = 1'b1;
   logic        in_underrun = 1'b0;
   logic [31:0] in_pixel = '0;
   logic        out_valid;
   logic [7:0]  out_red, out_green, out_blue;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   int       sh_bpp;
   int       sh_off [3];
   int       sh_len [3];
   logic [7:0] sh_dflt [3];
   logic [7:0] last_exp [3];

   always #10 clk = ~clk;

   pix_comp_extract i_pix_comp_extract (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .in_valid(in_valid), .in_active(in_active), .in_underrun(in_underrun), .in_pixel(in_pixel),
      .out_valid(out_valid), .out_red(out_red), .out_green(out_green), .out_blue(out_blue)
   );

   task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   function automatic logic [7:0] model(int c, logic [31:0] pix, bit act, bit und);
      logic [31:0] m, f;
      logic [63:0] x;
      int L, O;
      L = sh_len[c];
      O = sh_off[c];
      if (!act || und || L == 0) return sh_dflt[c];
      m = '0;
      for (int b = 0; b < 4; b++) if (b <= sh_bpp) m[b*8 +: 8] = pix[b*8 +: 8];
      f = '0;
      for (int i = 0; i < L; i++) if (O + i < 32) f[i] = m[O + i];
      if (L >= 8) return 8'(f >> (L - 8));
      x = '0;
      for (int k = 0; k < 8; k++) x = (x << L) | 64'(f);
      return 8'(x >> (8 * L - 8));
   endfunction

   task automatic wr(logic [1:0] a, logic [31:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_fmt(int bytes);
      wr(2'd0, 32'((bytes - 1) << 3) | 32'h0000_0004);
      sh_bpp = bytes - 1;
   endtask

   task automatic set_sel(int c, int off, int len, logic [7:0] dv);
      wr(2'(c + 1), {8'hA5, dv, 4'h9, 4'(len), 3'b111, 5'(off)});
      sh_off[c] = off; sh_len[c] = len; sh_dflt[c] = dv;
   endtask

   task automatic push(string rq, logic [31:0] pix, bit act, bit und);
      in_valid = 1'b1; in_pixel = pix; in_active = act; in_underrun = und;
      for (int c = 0; c < 3; c++) last_exp[c] = model(c, pix, act, und);
      @(negedge clk);
      chk("R10", "out_valid", 32'(out_valid), 32'd1);
      chk(rq, "red",   32'(out_red),   32'(last_exp[0]));
      chk(rq, "green", 32'(out_green), 32'(last_exp[1]));
      chk(rq, "blue",  32'(out_blue),  32'(last_exp[2]));
      in_valid = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      sh_bpp = 0;
      for (int c = 0; c < 3; c++) begin sh_off[c] = 0; sh_len[c] = 0; sh_dflt[c] = 8'h00; end
      chk("R1", "out_valid", 32'(out_valid), 32'd0);
      chk("R1", "rgb", {8'h0, out_red, out_green, out_blue}, 32'h0);
      push("R1", 32'hFFFF_FFFF, 1'b1, 1'b0);
   endtask

   task automatic t_rgb565();
      set_fmt(2);
      set_sel(0, 11, 5, 8'h11);
      set_sel(1, 5, 6, 8'h22);
      set_sel(2, 0, 5, 8'h33);
      push("R5", 32'h0000_F81F, 1'b1, 1'b0);
      push("R5", 32'h0000_07E0, 1'b1, 1'b0);
      push("R4", 32'hDEAD_1234, 1'b1, 1'b0);
      push("R5", 32'h0000_FFBE, 1'b1, 1'b0);
      set_sel(2, 1, 3, 8'h33);
      push("R5", 32'h0000_000A, 1'b1, 1'b0);
   endtask

   task automatic t_888();
      set_fmt(3);
      set_sel(0, 16, 8, 8'h01);
      set_sel(1, 8, 8, 8'h02);
      set_sel(2, 0, 8, 8'h03);
      push("R6", 32'h77A5_C3E1, 1'b1, 1'b0);
      push("R6", 32'h0012_3456, 1'b1, 1'b0);
   endtask

   task automatic t_trunc();
      set_fmt(4);
      set_sel(0, 0, 12, 8'h00);
      set_sel(1, 4, 15, 8'h00);
      set_sel(2, 20, 9, 8'h00);
      push("R6", 32'h9ABC_DEF1, 1'b1, 1'b0);
      push("R6", 32'h5A5A_0FF0, 1'b1, 1'b0);
   endtask

   task automatic t_mask();
      set_fmt(1);
      set_sel(0, 8, 8, 8'h40);
      set_sel(1, 4, 8, 8'h41);
      set_sel(2, 0, 4, 8'h42);
      push("R3", 32'hFFFF_FF96, 1'b1, 1'b0);
      set_fmt(2);
      push("R3", 32'hFFFF_C396, 1'b1, 1'b0);
      set_fmt(4);
      set_sel(2, 28, 8, 8'h42);
      push("R4", 32'hB000_0000, 1'b1, 1'b0);
   endtask

   task automatic t_zero_len();
      set_sel(0, 0, 0, 8'h5A);
      set_sel(1, 0, 8, 8'h66);
      set_sel(2, 8, 4, 8'h77);
      push("R7", 32'h1234_5678, 1'b1, 1'b0);
   endtask

   task automatic t_blank();
      set_sel(0, 16, 8, 8'hC1);
      set_sel(1, 8, 8, 8'hC2);
      set_sel(2, 0, 8, 8'hC3);
      push("R8", 32'h00FF_FFFF, 1'b0, 1'b0);
      push("R8", 32'h0012_3456, 1'b1, 1'b0);
   endtask

   task automatic t_underrun();
      push("R9", 32'h00AB_CDEF, 1'b1, 1'b1);
      push("R9", 32'h00AB_CDEF, 1'b0, 1'b1);
   endtask

   task automatic t_latency_hold();
      push("R10", 32'h0011_2233, 1'b1, 1'b0);
      in_pixel = 32'hFFFF_FFFF; in_active = 1'b0; in_underrun = 1'b1;
      @(negedge clk);
      chk("R10", "out_valid idle", 32'(out_valid), 32'd0);
      @(negedge clk);
      chk("R11", "red hold",   32'(out_red),   32'(last_exp[0]));
      chk("R11", "green hold", 32'(out_green), 32'(last_exp[1]));
      chk("R11", "blue hold",  32'(out_blue),  32'(last_exp[2]));
      in_active = 1'b1; in_underrun = 1'b0;
   endtask

   task automatic t_indep();
      set_sel(1, 4, 3, 8'hEE);
      push("R12", 32'h0011_2233, 1'b1, 1'b0);
      set_sel(0, 0, 0, 8'h99);
      push("R12", 32'h0011_2233, 1'b1, 1'b0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R10 watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_rgb565();
      t_888();
      t_trunc();
      t_mask();
      t_zero_len();
      t_blank();
      t_underrun();
      t_latency_hold();
      t_indep();
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule